// File: doc/BRIEF.md
# Lane Word Polarity and Ordering Transform

This block applies a set of optional, reversible transforms to each data word on one lane of a serial transceiver. It can flip the polarity of every bit, exchange the byte order of a multi-byte word and mirror the bit order of the whole word. Each transform has its own enable, and a bypass control passes words through unchanged no matter how the other enables are set. Encoding, decoding and alignment are handled elsewhere, so the stage treats every word as an opaque vector. It works the same way on raw words and on encoded words.

One instance sits on the transmit side and a matching instance sits at the same point of the receive side. The `RX_SIDE` parameter reverses the order in which the stage applies the transforms, so a receive instance undoes a transmit instance that has the same enables. Words enter with a valid strobe and leave one clock later through a single output register. The control inputs are sampled together with the word they apply to.

Top module: `pbr_lane_xform`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted word, `out_vld` is 0 and `out_data` is all zeros.
- R2: `out_vld` equals the value `in_vld` had one clock earlier, and a word accepted on one edge appears on `out_data` after the next edge.
- R3: In a cycle where `in_vld` is low, `out_data` keeps its previous value.
- R4: When `cfg_bypass` is 1 for an accepted word, the output word equals the input word, whatever the other three controls are.
- R5: When only inversion is enabled, every output bit is the complement of the matching input bit.
- R6: When only bit reversal is enabled, output bit i equals input bit W-1-i.
- R7: When only byte swap is enabled and W is a multiple of 16, output byte k (bits 8k+7..8k) equals input byte W/8-1-k. For any other W the swap has no effect.
- R8: With several transforms enabled, a transmit instance (RX_SIDE=0) applies bit reversal first, then byte swap, then inversion. A receive instance (RX_SIDE=1) applies them in the opposite order. A transmit word passed through a receive instance with the same controls returns to its original value.
- R9: The controls present in the cycle a word is accepted decide that word's transform. A control change affects only the words accepted after it, and every output word is produced entirely under one setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Input word valid |
| in_data | input | W | Input word |
| cfg_bypass | input | 1 | Pass words unchanged, overriding the other controls |
| cfg_inv | input | 1 | Enable polarity inversion |
| cfg_swap | input | 1 | Enable byte order swap |
| cfg_rev | input | 1 | Enable bit order reversal |
| out_vld | output | 1 | Output word valid |
| out_data | output | W | Transformed word |

## Verification
The assertions assume that `in_vld`, `in_data` and the four control inputs are driven to known values from time zero. They also assume that the controls are steady around each clock edge, because every check compares `out_data` with the inputs of the previous cycle. The bench changes data and controls only on the falling clock edge, and it holds `in_vld` low with defined data through reset. The controls are changed every four words so that new settings arrive back to back with valid data, never in an idle gap alone.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  // Effective per-stage enables after the bypass override.
  typedef struct packed {
    logic inv;
    logic swap;
    logic rev;
  } pbr_en_t;

  function automatic pbr_en_t pbr_gate(
    input logic bypass,
    input logic inv,
    input logic swap,
    input logic rev
  );
    pbr_en_t e;
    e.inv  = inv  & ~bypass;
    e.swap = swap & ~bypass;
    e.rev  = rev  & ~bypass;
    return e;
  endfunction

endpackage

// File: rtl/pbr_bitrev.sv
module pbr_bitrev #(
  parameter int W = 16
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] mirrored;

  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign mirrored[i] = din[W-1-i];
  end

  assign dout = en ? mirrored : din;

endmodule

// File: rtl/pbr_byteswap.sv
module pbr_byteswap #(
  parameter int W = 16
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int  NBYTES  = W / 8;
  localparam bit  SWAP_OK = (W % 16) == 0;

  if (SWAP_OK) begin : g_swap
    logic [W-1:0] swapped;
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
      assign swapped[8*k +: 8] = din[8*(NBYTES-1-k) +: 8];
    end
    assign dout = en ? swapped : din;
  end else begin : g_noswap
    // Byte lanes do not pair up: the enable selects identical words.
    assign dout = en ? din : din;
  end

endmodule

// File: rtl/pbr_invert.sv
module pbr_invert #(
  parameter int W = 16
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  assign dout = din ^ {W{en}};

endmodule

// File: rtl/pbr_lane_xform.sv
module pbr_lane_xform
  import pbr_pkg::*;
#(
  parameter int W       = 16,
  parameter bit RX_SIDE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  input  logic         cfg_bypass,
  input  logic         cfg_inv,
  input  logic         cfg_swap,
  input  logic         cfg_rev,
  output logic         out_vld,
  output logic [W-1:0] out_data
);

  localparam bit SWAP_OK = (W % 16) == 0;

  pbr_en_t      en;
  logic [W-1:0] s0, s1, s2, s3;
  logic [W-1:0] data_d, data_q;
  logic         vld_d, vld_q;

  assign en = pbr_gate(cfg_bypass, cfg_inv, cfg_swap, cfg_rev);
  assign s0 = in_data;

  if (!RX_SIDE) begin : g_tx_order
    pbr_bitrev   #(.W(W)) u_rev  (.en(en.rev),  .din(s0), .dout(s1));
    pbr_byteswap #(.W(W)) u_swap (.en(en.swap), .din(s1), .dout(s2));
    pbr_invert   #(.W(W)) u_inv  (.en(en.inv),  .din(s2), .dout(s3));
  end else begin : g_rx_order
    pbr_invert   #(.W(W)) u_inv  (.en(en.inv),  .din(s0), .dout(s1));
    pbr_byteswap #(.W(W)) u_swap (.en(en.swap), .din(s1), .dout(s2));
    pbr_bitrev   #(.W(W)) u_rev  (.en(en.rev),  .din(s2), .dout(s3));
  end

  // Next-state logic: the word register loads only on an accepted word.
  always_comb begin
    vld_d  = in_vld;
    data_d = data_q;
    if (in_vld) begin
      data_d = s3;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_data = data_q;

  // Assertion support: set once a full cycle has passed since reset.
  logic chk_armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_armed <= 1'b0;
    else        chk_armed <= 1'b1;
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed |-> (out_vld == $past(in_vld)));  // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && !$past(in_vld)) |-> $stable(out_data));  // R3

  AST_BYPASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(in_vld && cfg_bypass)) |-> (out_data == $past(in_data)));  // R4

  AST_INV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(in_vld && !cfg_bypass && cfg_inv && !cfg_swap && !cfg_rev))
    |-> (out_data == ~$past(in_data)));  // R5

  AST_REV_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(in_vld && !cfg_bypass && !cfg_inv && !cfg_swap && cfg_rev))
    |-> ($countones(out_data) == $countones($past(in_data))));  // R6

  AST_SWAP_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(in_vld && !cfg_bypass && !cfg_inv && cfg_swap && !cfg_rev))
    |-> ($countones(out_data) == $countones($past(in_data))));  // R7

  AST_SWAP_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && !SWAP_OK && $past(in_vld && !cfg_bypass && !cfg_inv && cfg_swap && !cfg_rev))
    |-> (out_data == $past(in_data)));  // R7

endmodule

// File: tb/tb_pbr_lane_xform.sv
`timescale 1ns/1ps
module tb_pbr_lane_xform;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [15:0] in_data = '0;
  logic [19:0] in_data20 = '0;
  logic        c_byp = 1'b0, c_inv = 1'b0, c_swp = 1'b0, c_rev = 1'b0;
  logic        r_byp = 1'b0, r_inv = 1'b0, r_swp = 1'b0, r_rev = 1'b0;

  logic        tx_vld, rx_vld, w20_vld;
  logic [15:0] tx_data, rx_data;
  logic [19:0] w20_data;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  pbr_lane_xform #(.W(16), .RX_SIDE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .cfg_bypass(c_byp), .cfg_inv(c_inv), .cfg_swap(c_swp), .cfg_rev(c_rev),
    .out_vld(tx_vld), .out_data(tx_data));

  pbr_lane_xform #(.W(16), .RX_SIDE(1'b1)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_vld(tx_vld), .in_data(tx_data),
    .cfg_bypass(r_byp), .cfg_inv(r_inv), .cfg_swap(r_swp), .cfg_rev(r_rev),
    .out_vld(rx_vld), .out_data(rx_data));

  pbr_lane_xform #(.W(20), .RX_SIDE(1'b0)) u_w20 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data20),
    .cfg_bypass(c_byp), .cfg_inv(c_inv), .cfg_swap(c_swp), .cfg_rev(c_rev),
    .out_vld(w20_vld), .out_data(w20_data));

  // c = {bypass, inv, swap, rev}
  function automatic logic [31:0] model(input logic [31:0] d, input int w,
                                        input logic [3:0] c, input bit rx);
    logic [31:0] mask, x, t;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    x = d & mask;
    if (c[3]) return x;
    if (rx && c[2]) x = x ^ mask;
    if (!rx && c[0]) begin
      t = '0;
      for (int i = 0; i < w; i++) t[i] = x[w-1-i];
      x = t;
    end
    if (c[1] && (w % 16 == 0)) begin
      t = '0;
      for (int k = 0; k < w/8; k++)
        for (int j = 0; j < 8; j++) t[8*k+j] = x[8*(w/8-1-k)+j];
      x = t;
    end
    if (rx && c[0]) begin
      t = '0;
      for (int i = 0; i < w; i++) t[i] = x[w-1-i];
      x = t;
    end
    if (!rx && c[2]) x = x ^ mask;
    return x;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_for(input logic [3:0] c, input bit newcfg);
    if (newcfg)          return "R9";
    if (c[3])            return "R4";
    if (c[2:0] == 3'b100) return "R5";
    if (c[2:0] == 3'b001) return "R6";
    if (c[2:0] == 3'b010) return "R7";
    return "R8";
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0]  cfg, pcfg, ppcfg;
    logic [15:0] d, pd, ppd;
    logic [19:0] d20, pd20;
    bit          pv, ppv, pnew;
    pcfg = '0; ppcfg = '0; pd = '0; ppd = '0; pd20 = '0;
    pv = 1'b0; ppv = 1'b0; pnew = 1'b0;

    repeat (3) @(negedge clk);
    // R1: outputs clear while in reset
    chk(tx_vld == 1'b0 && tx_data == '0, "R1 reset", {tx_vld, tx_data}, 0);
    chk(w20_vld == 1'b0 && w20_data == '0, "R1 reset w20", {w20_vld, w20_data}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_vld == 1'b0 && tx_data == '0, "R1 after release", {tx_vld, tx_data}, 0);
    chk(rx_vld == 1'b0 && rx_data == '0, "R1 after release rx", {rx_vld, rx_data}, 0);

    for (int i = 0; i < 65536 + 2; i++) begin
      bit live;
      live = (i < 65536);
      cfg  = 4'(i >> 2);
      d    = 16'(i * 40503);
      d20  = {4'(i) ^ 4'h5, d};
      // drive this cycle's word; receive side takes the previous word's controls
      in_vld = live;
      if (live) begin
        in_data = d; in_data20 = d20;
        {c_byp, c_inv, c_swp, c_rev} = cfg;
      end
      {r_byp, r_inv, r_swp, r_rev} = pcfg;
      @(negedge clk);
      // results of the word driven above
      chk(tx_vld == live, "R2 valid delay", 32'(tx_vld), 32'(live));
      if (live) begin
        logic [31:0] e16, e20;
        e16 = model({16'h0, d}, 16, cfg, 1'b0);
        e20 = model({12'h0, d20}, 20, cfg, 1'b0);
        chk(tx_data == e16[15:0], tag_for(cfg, (i % 4) == 0), {16'h0, tx_data}, e16);
        chk(w20_data == e20[19:0], (cfg[1] && !cfg[3]) ? "R7 w20" : "R8 w20",
            {12'h0, w20_data}, e20);
      end
      // receive side returns the word driven one iteration earlier
      chk(rx_vld == pv, "R2 rx valid", 32'(rx_vld), 32'(pv));
      if (pv) chk(rx_data == pd, "R8 roundtrip", {16'h0, rx_data}, {16'h0, pd});
      ppv = pv; ppd = pd; ppcfg = pcfg;
      pv = live; pd = d; pcfg = cfg; pd20 = d20; pnew = 1'b0;
    end

    // R3: idle cycles with changing data and controls leave outputs untouched
    in_vld = 1'b1; in_data = 16'h1234; in_data20 = 20'hABCDE;
    {c_byp, c_inv, c_swp, c_rev} = 4'b0001;
    @(negedge clk);
    chk(tx_data == 16'h2C48, "R6 rev 1234", {16'h0, tx_data}, 32'h2C48);
    in_vld = 1'b0;
    for (int k = 0; k < 4; k++) begin
      in_data = 16'(16'hF00F + k); in_data20 = 20'(k);
      {c_byp, c_inv, c_swp, c_rev} = 4'(k * 5);
      @(negedge clk);
      chk(tx_vld == 1'b0, "R2 idle valid", 32'(tx_vld), 0);
      chk(tx_data == 16'h2C48, "R3 hold", {16'h0, tx_data}, 32'h2C48);
    end
    // R7 fixed vector: swap only
    in_vld = 1'b1; in_data = 16'hA55A; in_data20 = 20'h12345;
    {c_byp, c_inv, c_swp, c_rev} = 4'b0010;
    @(negedge clk);
    chk(tx_data == 16'h5AA5, "R7 swap A55A", {16'h0, tx_data}, 32'h5AA5);
    chk(w20_data == 20'h12345, "R7 w20 noop", {12'h0, w20_data}, 32'h12345);
    in_vld = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule